// File: doc/BRIEF.md
# Multiplexed Segment LCD Drive Sequencer

This block turns a small on-chip pixel store into the drive-level codes for a multiplexed segment LCD using 1/2 bias. A processor writes pixels through a 16-address window. A bank flag decides whether each write lands in the pixel store or is handed to an external general-purpose RAM through a pass-through write enable. Each window address belongs to one segment pin, and each bit of the stored byte is the pixel where that segment crosses one common line.

A frame sequencer activates the commons one after another. Each common gets two equal phases whose length is set by a power-of-two prescaler on the source clock. Every pin carries a 2-bit code for ground, half or full LCD voltage, and the analog stage outside the block turns these codes into voltages. The number of commons can be two, three or four. In four-common operation the last segment pin becomes the fourth common. A change of common count or divider waits for the current frame to end. Reset and the halt input force every pin to a dark state.

Top module: `lcdm_top`

## Requirements
- R1: Addresses 0x40 to 0x4F form the window. A write there with `bank_sel`=1 updates pixel entry (addr-0x40). With `bank_sel`=0 the pixel store is unchanged and `gp_wr_en` is high in that same cycle. A write outside the window touches neither.
- R2: Entry i drives segment pin i, and bit n of the entry is the pixel on common n (1 lit, 0 dark). Pixel changes reach the pins without any further command. Reset clears every entry.
- R3: `rd_data` is combinational. For a window address with `bank_sel`=1 it returns the entry with the bits at and above the active common count of `cfg_duty` forced to 0. In every other case it returns 0.
- R4: `cfg_duty` 00 selects two commons (0,1), 01 selects three (0..2), and 10 or 11 selects four (0..3, the fourth driven on segment pin 15). Commons activate in ascending order and wrap to common 0 after the last one.
- R5: A common pin that is unused is held at half level: pin 2 with two commons. With two or three commons, segment pin 15 acts as an ordinary segment.
- R6: Each phase lasts 2^k clock cycles, with k = `cfg_div`+2. A `cfg_div` value above 6 gives k = 8.
- R7: Level codes are 00 ground, 01 half and 10 full, and 11 never appears. In the first phase the active common drives full, and in the second it drives ground. Inactive commons drive half. A lit segment drives the opposite extreme from the active common, and a dark segment drives the same level as the active common.
- R8: All pins read half while reset is asserted and from the cycle after `halt` rises. After `halt` falls, the sequence restarts at common 0, first phase, with full length and the current configuration. Pixel contents survive halt.
- R9: A change of `cfg_duty` or `cfg_div` while running takes effect only when the last phase of the current frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Forces dark outputs and restarts the sequence |
| bank_sel | input | 1 | 1 selects the pixel store in the window, 0 the external RAM |
| wr_en | input | 1 | Processor write strobe |
| addr | input | 8 | Processor address |
| wdata | input | 8 | Processor write data |
| rd_data | output | 8 | Window read data |
| gp_wr_en | output | 1 | Write enable passed to external general-purpose RAM |
| cfg_duty | input | 2 | Common count select |
| cfg_div | input | 3 | Prescaler exponent select (k = value + 2) |
| com_lvl | output | 6 | Level codes of common pins 0..2, two bits each |
| seg_lvl | output | 32 | Level codes of segment pins 0..15, two bits each |

## Verification
The bench aims at the shared pin 15. A design that failed to swap it into common mode at four commons would light or blank column 15 where the fourth common should be pulsing. It changes the common count in the middle of a frame: a design that applied the change at once would truncate the frame, skipping commons 2 and 3 or moving to the new phase length early. It also checks bank-0 and out-of-window writes, the read mask at two commons, and the saturated divider code. Errors there show up as corrupted pixels, stale upper read bits, or a phase length other than 256 cycles.

// File: rtl/lcdm_pkg.sv
package lcdm_pkg;

   typedef enum logic [1:0] {
      LV_GND  = 2'b00,
      LV_HALF = 2'b01,
      LV_FULL = 2'b10
   } lvl_t;

   // index of the last common in a frame for a duty code
   function automatic logic [1:0] last_com(input logic [1:0] duty);
      case (duty)
         2'b00:   return 2'd1;
         2'b01:   return 2'd2;
         default: return 2'd3;
      endcase
   endfunction

   // commons that exist for a duty code, one bit per common
   function automatic logic [3:0] com_mask(input logic [1:0] duty);
      case (duty)
         2'b00:   return 4'b0011;
         2'b01:   return 4'b0111;
         default: return 4'b1111;
      endcase
   endfunction

endpackage

// File: rtl/lcdm_prescaler.sv
module lcdm_prescaler #(
   parameter int K_MAX = 8,
   localparam int KW = $clog2(K_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [KW-1:0] k_exp,
   output logic          tick
);
   logic [K_MAX-1:0] cnt;
   logic [K_MAX-1:0] lim;

   // ones in the low k_exp bits: terminal count of a 2^k period
   assign lim  = ~({K_MAX{1'b1}} << k_exp);
   assign tick = (cnt == lim) && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clr || tick) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/lcdm_seq.sv
module lcdm_seq
   import lcdm_pkg::*;
#(
   parameter int K_MIN = 2,
   parameter int K_MAX = 8,
   parameter int DIVW  = 3,
   parameter int NCOM  = 4,
   localparam int KW = $clog2(K_MAX + 1),
   localparam int CW = $clog2(NCOM)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            halt,
   input  logic            tick,
   input  logic [1:0]      cfg_duty,
   input  logic [DIVW-1:0] cfg_div,
   output logic [CW-1:0]   com_idx,
   output logic            phase_b,
   output logic [1:0]      duty_act,
   output logic [KW-1:0]   k_act,
   output logic            hold,
   output logic            frame_end
);
   logic started;

   function automatic logic [KW-1:0] div2k(input logic [DIVW-1:0] d);
      if (int'(d) > K_MAX - K_MIN) return KW'(K_MAX);
      return KW'(int'(d) + K_MIN);
   endfunction

   assign hold      = halt || !started;
   assign frame_end = tick && phase_b && (com_idx == CW'(last_com(duty_act)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started  <= 1'b0;
         com_idx  <= '0;
         phase_b  <= 1'b0;
         duty_act <= 2'b00;
         k_act    <= KW'(K_MIN);
      end else if (hold) begin
         started  <= 1'b1;
         com_idx  <= '0;
         phase_b  <= 1'b0;
         duty_act <= cfg_duty;
         k_act    <= div2k(cfg_div);
      end else if (tick) begin
         if (!phase_b) begin
            phase_b <= 1'b1;
         end else begin
            phase_b <= 1'b0;
            if (frame_end) begin
               com_idx  <= '0;
               duty_act <= cfg_duty;
               k_act    <= div2k(cfg_div);
            end else begin
               com_idx  <= com_idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/lcdm_dispmem.sv
module lcdm_dispmem #(
   parameter int NSEG = 16,
   parameter int NCOM = 4,
   parameter int AW   = 8,
   parameter int DW   = 8,
   parameter int BASE = 64,
   localparam int IW = $clog2(NSEG)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 bank_sel,
   input  logic [AW-1:0]        addr,
   input  logic [DW-1:0]        wdata,
   input  logic [NCOM-1:0]      rd_mask,
   output logic [DW-1:0]        rd_data,
   output logic                 gp_wr_en,
   output logic [NSEG*NCOM-1:0] pix
);
   logic [NCOM-1:0] mem [NSEG];
   logic [AW-1:0]   off;
   logic [IW-1:0]   idx;
   logic            in_win;
   logic            disp_we;

   assign off     = addr - AW'(BASE);
   assign idx     = off[IW-1:0];
   assign in_win  = (addr >= AW'(BASE)) && (off < AW'(NSEG));
   assign disp_we = wr_en && in_win && bank_sel;
   assign gp_wr_en = wr_en && in_win && !bank_sel;

   assign rd_data = (in_win && bank_sel)
                  ? {{(DW-NCOM){1'b0}}, mem[idx] & rd_mask}
                  : '0;

   for (genvar i = 0; i < NSEG; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          mem[i] <= '0;
         else if (disp_we && idx == IW'(i))   mem[i] <= wdata[NCOM-1:0];
      end
      assign pix[i*NCOM +: NCOM] = mem[i];
   end
endmodule

// File: rtl/lcdm_wavegen.sv
module lcdm_wavegen
   import lcdm_pkg::*;
#(
   parameter int NSEG     = 16,
   parameter int NCOM     = 4,
   parameter int NCOM_PIN = 3,
   localparam int CW = $clog2(NCOM)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   hold,
   input  logic [CW-1:0]          com_idx,
   input  logic                   phase_b,
   input  logic [1:0]             duty_act,
   input  logic [NSEG*NCOM-1:0]   pix,
   output logic [NCOM_PIN*2-1:0]  com_lvl,
   output logic [NSEG*2-1:0]      seg_lvl
);
   lvl_t act_lv, opp_lv;
   logic four_com;

   assign act_lv   = phase_b ? LV_GND : LV_FULL;
   assign opp_lv   = phase_b ? LV_FULL : LV_GND;
   assign four_com = duty_act[1];

   for (genvar j = 0; j < NCOM_PIN; j++) begin : g_com
      lvl_t nxt;
      assign nxt = (com_idx == CW'(j)) ? act_lv : LV_HALF;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    com_lvl[2*j +: 2] <= LV_HALF;
         else if (hold) com_lvl[2*j +: 2] <= LV_HALF;
         else           com_lvl[2*j +: 2] <= nxt;
      end
   end

   for (genvar i = 0; i < NSEG; i++) begin : g_seg
      lvl_t            nxt;
      logic [NCOM-1:0] col;
      assign col = pix[i*NCOM +: NCOM];
      if (i == NSEG - 1) begin : g_shared
         // last segment pin doubles as the extra common
         assign nxt = four_com ? ((com_idx == CW'(NCOM - 1)) ? act_lv : LV_HALF)
                               : (col[com_idx] ? opp_lv : act_lv);
      end else begin : g_plain
         assign nxt = col[com_idx] ? opp_lv : act_lv;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    seg_lvl[2*i +: 2] <= LV_HALF;
         else if (hold) seg_lvl[2*i +: 2] <= LV_HALF;
         else           seg_lvl[2*i +: 2] <= nxt;
      end
   end
endmodule

// File: rtl/lcdm_top.sv
module lcdm_top
   import lcdm_pkg::*;
#(
   parameter int NSEG     = 16,
   parameter int NCOM     = 4,
   parameter int NCOM_PIN = 3,
   parameter int AW       = 8,
   parameter int DW       = 8,
   parameter int WIN_BASE = 64,
   parameter int K_MIN    = 2,
   parameter int K_MAX    = 8,
   parameter int DIVW     = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  halt,
   input  logic                  bank_sel,
   input  logic                  wr_en,
   input  logic [AW-1:0]         addr,
   input  logic [DW-1:0]         wdata,
   output logic [DW-1:0]         rd_data,
   output logic                  gp_wr_en,
   input  logic [1:0]            cfg_duty,
   input  logic [DIVW-1:0]       cfg_div,
   output logic [NCOM_PIN*2-1:0] com_lvl,
   output logic [NSEG*2-1:0]     seg_lvl
);
   localparam int KW = $clog2(K_MAX + 1);
   localparam int CW = $clog2(NCOM);

   if (NCOM != 4 || NCOM_PIN != NCOM - 1) begin : g_bad_com
      $error("lcdm_top: four commons with one shared segment pin required");
   end
   if (K_MIN < 1 || K_MAX < K_MIN) begin : g_bad_k
      $error("lcdm_top: prescaler exponent range invalid");
   end
   if ((1 << DIVW) < K_MAX - K_MIN + 1) begin : g_bad_divw
      $error("lcdm_top: divider field too narrow");
   end
   if (WIN_BASE + NSEG > (1 << AW) || NCOM > DW) begin : g_bad_win
      $error("lcdm_top: window does not fit the bus");
   end

   logic                 tick, hold, frame_end, phase_b;
   logic [CW-1:0]        com_idx;
   logic [1:0]           duty_act;
   logic [KW-1:0]        k_act;
   logic [NSEG*NCOM-1:0] pix;
   logic [3:0]           live_mask;

   assign live_mask = com_mask(cfg_duty);

   lcdm_prescaler #(.K_MAX(K_MAX)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(hold), .k_exp(k_act), .tick(tick)
   );

   lcdm_seq #(.K_MIN(K_MIN), .K_MAX(K_MAX), .DIVW(DIVW), .NCOM(NCOM)) u_seq (
      .clk(clk), .rst_n(rst_n), .halt(halt), .tick(tick),
      .cfg_duty(cfg_duty), .cfg_div(cfg_div),
      .com_idx(com_idx), .phase_b(phase_b), .duty_act(duty_act),
      .k_act(k_act), .hold(hold), .frame_end(frame_end)
   );

   lcdm_dispmem #(.NSEG(NSEG), .NCOM(NCOM), .AW(AW), .DW(DW), .BASE(WIN_BASE)) u_mem (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bank_sel(bank_sel),
      .addr(addr), .wdata(wdata), .rd_mask(live_mask[NCOM-1:0]),
      .rd_data(rd_data), .gp_wr_en(gp_wr_en), .pix(pix)
   );

   lcdm_wavegen #(.NSEG(NSEG), .NCOM(NCOM), .NCOM_PIN(NCOM_PIN)) u_wave (
      .clk(clk), .rst_n(rst_n), .hold(hold), .com_idx(com_idx),
      .phase_b(phase_b), .duty_act(duty_act), .pix(pix),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl)
   );
endmodule

// File: rtl/lcdm_chk.sv
module lcdm_chk #(
   parameter int NSEG     = 16,
   parameter int NCOM     = 4,
   parameter int NCOM_PIN = 3,
   parameter int AW       = 8,
   parameter int DW       = 8,
   parameter int WIN_BASE = 64,
   parameter int KW       = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  halt,
   input logic                  hold,
   input logic                  frame_end,
   input logic                  bank_sel,
   input logic                  wr_en,
   input logic [AW-1:0]         addr,
   input logic [DW-1:0]         rd_data,
   input logic                  gp_wr_en,
   input logic [1:0]            duty_act,
   input logic [KW-1:0]         k_act,
   input logic [NCOM_PIN*2-1:0] com_lvl,
   input logic [NSEG*2-1:0]     seg_lvl
);
   logic                in_win, any_bad, all_half, plain_half;
   logic [NCOM_PIN-1:0] com_on;

   assign in_win = (int'(addr) >= WIN_BASE) && (int'(addr) < WIN_BASE + NSEG);

   always_comb begin
      any_bad    = 1'b0;
      all_half   = 1'b1;
      plain_half = 1'b0;
      for (int j = 0; j < NCOM_PIN; j++) begin
         com_on[j] = (com_lvl[2*j +: 2] != 2'b01);
         if (com_lvl[2*j +: 2] == 2'b11) any_bad = 1'b1;
         if (com_lvl[2*j +: 2] != 2'b01) all_half = 1'b0;
      end
      for (int i = 0; i < NSEG; i++) begin
         if (seg_lvl[2*i +: 2] == 2'b11) any_bad = 1'b1;
         if (seg_lvl[2*i +: 2] != 2'b01) all_half = 1'b0;
         if (i < NSEG - 1 && seg_lvl[2*i +: 2] == 2'b01) plain_half = 1'b1;
      end
   end

   a_r1_gp_bank0: assert property (@(posedge clk) disable iff (!rst_n)
      gp_wr_en |-> (wr_en && !bank_sel && in_win));
   a_r3_rd_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (!bank_sel || !in_win) |-> (rd_data == '0));
   a_r3_rd_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DW-1:NCOM] == '0);
   a_r7_no_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      !any_bad);
   a_r7_one_active_com: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(com_on) <= 1);
   a_r7_seg_never_half: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(hold) |-> !plain_half);
   a_r8_halt_dark: assert property (@(posedge clk) disable iff (!rst_n)
      $past(halt) |-> all_half);
   a_r5_com2_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $past(duty_act == 2'b00) |-> (com_lvl[5:4] == 2'b01));
   a_r9_cfg_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(frame_end) && !$past(hold)) |-> ($stable(duty_act) && $stable(k_act)));
endmodule

bind lcdm_top lcdm_chk u_chk (
   .clk(clk), .rst_n(rst_n), .halt(halt), .hold(hold), .frame_end(frame_end),
   .bank_sel(bank_sel), .wr_en(wr_en), .addr(addr), .rd_data(rd_data),
   .gp_wr_en(gp_wr_en), .duty_act(duty_act), .k_act(k_act),
   .com_lvl(com_lvl), .seg_lvl(seg_lvl)
);

// File: tb/lcdm_top_tb.sv
module lcdm_top_tb;
   localparam logic [1:0] L_GND = 2'b00, L_HALF = 2'b01, L_FULL = 2'b10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        halt = 1'b0;
   logic        bank_sel = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [7:0]  wdata = 8'h00;
   logic [7:0]  rd_data;
   logic        gp_wr_en;
   logic [1:0]  cfg_duty = 2'b00;
   logic [2:0]  cfg_div = 3'd0;
   logic [5:0]  com_lvl;
   logic [31:0] seg_lvl;

   int nchk = 0;
   int nfail = 0;
   logic [3:0] mdl [16];

   always #5 clk = ~clk;

   lcdm_top u_dut (
      .clk(clk), .rst_n(rst_n), .halt(halt), .bank_sel(bank_sel),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data),
      .gp_wr_en(gp_wr_en), .cfg_duty(cfg_duty), .cfg_div(cfg_div),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int ncom(input logic [1:0] d);
      return (d == 2'b00) ? 2 : (d == 2'b01) ? 3 : 4;
   endfunction

   function automatic int per(input logic [2:0] d);
      return 1 << ((d > 3'd6) ? 8 : int'(d) + 2);
   endfunction

   function automatic logic [5:0] exp_com(input int c, input int ph);
      logic [5:0] v;
      for (int j = 0; j < 3; j++)
         v[2*j +: 2] = (j == c) ? (ph != 0 ? L_GND : L_FULL) : L_HALF;
      return v;
   endfunction

   function automatic logic [31:0] exp_seg(input int c, input int ph, input logic [1:0] d);
      logic [31:0] v;
      logic [1:0] act, opp;
      act = (ph != 0) ? L_GND : L_FULL;
      opp = (ph != 0) ? L_FULL : L_GND;
      for (int i = 0; i < 16; i++) begin
         if (i == 15 && d[1]) v[2*i +: 2] = (c == 3) ? act : L_HALF;
         else                 v[2*i +: 2] = mdl[i][c] ? opp : act;
      end
      return v;
   endfunction

   // write one byte; gp_wr_en is checked inside the write cycle (R1)
   task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic bk);
      bit inw;
      inw = (a >= 8'h40) && (a <= 8'h4F);
      addr = a; wdata = d; bank_sel = bk; wr_en = 1'b1;
      #1;
      chk(gp_wr_en == (inw && !bk), "R1", "gp_wr_en", 64'(gp_wr_en), 64'(inw && !bk));
      @(negedge clk);
      wr_en = 1'b0;
      if (inw && bk) mdl[a - 8'h40] = d[3:0];
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic bk, input string req);
      logic [7:0] e;
      bit inw;
      inw = (a >= 8'h40) && (a <= 8'h4F);
      addr = a; bank_sel = bk;
      #1;
      e = (inw && bk) ? {4'h0, mdl[a - 8'h40] & ((cfg_duty == 2'b00) ? 4'h3 :
                                                 (cfg_duty == 2'b01) ? 4'h7 : 4'hF)} : 8'h00;
      chk(rd_data == e, req, "rd_data", 64'(rd_data), 64'(e));
   endtask

   task automatic phase_chk(input int c, input int ph, input logic [1:0] d, input string req);
      logic [5:0]  ec;
      logic [31:0] es;
      ec = exp_com(c, ph);
      es = exp_seg(c, ph, d);
      chk(com_lvl == ec, req, "com_lvl", 64'(com_lvl), 64'(ec));
      chk(seg_lvl == es, req, "seg_lvl", 64'(seg_lvl), 64'(es));
   endtask

   task automatic sync_frame();
      while (com_lvl[1:0] == L_FULL) @(negedge clk);
      while (com_lvl[1:0] != L_FULL) @(negedge clk);
   endtask

   // one full frame plus the wrap into the next (R2 R4 R7)
   task automatic frame_chk(input logic [1:0] d, input int p);
      int n;
      n = ncom(d);
      sync_frame();
      repeat (p / 2) @(negedge clk);
      for (int s = 0; s <= 2 * n; s++) begin
         phase_chk((s / 2) % n, s % 2, d, "R4");
         if (s != 2 * n) repeat (p) @(negedge clk);
      end
   endtask

   task automatic period_chk(input int p);
      int n;
      sync_frame();
      n = 0;
      while (com_lvl[1:0] == L_FULL) begin
         @(negedge clk);
         n++;
      end
      chk(n == p, "R6", "phase length", 64'(n), 64'(p));
   endtask

   task automatic all_dark_chk(input string req);
      chk(com_lvl == {3{L_HALF}}, req, "dark com", 64'(com_lvl), 64'({3{L_HALF}}));
      chk(seg_lvl == {16{L_HALF}}, req, "dark seg", 64'(seg_lvl), 64'({16{L_HALF}}));
   endtask

   task automatic apply_cfg(input logic [1:0] d, input logic [2:0] v);
      halt = 1'b1;
      cfg_duty = d;
      cfg_div = v;
      repeat (2) @(negedge clk);
      all_dark_chk("R8");
      halt = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end

   initial begin
      logic [1:0] d;
      logic [2:0] v;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 16; i++) mdl[i] = 4'h0;

      // reset state (R8, R2 cleared store)
      repeat (3) @(negedge clk);
      all_dark_chk("R8");
      rd_chk(8'h45, 1'b1, "R2");
      cfg_duty = 2'b10;
      rst_n = 1'b1;
      @(negedge clk);

      // directed pixel pattern, including the shared pin
      wr(8'h40, 8'h05, 1'b1);
      wr(8'h4F, 8'h0A, 1'b1);
      wr(8'h47, 8'hFF, 1'b1);
      rd_chk(8'h47, 1'b1, "R3");
      wr(8'h41, 8'h0F, 1'b0);          // bank 0: store untouched (R1)
      rd_chk(8'h41, 1'b1, "R1");
      rd_chk(8'h41, 1'b0, "R3");
      wr(8'h3F, 8'h0F, 1'b1);          // outside the window (R1)
      wr(8'h50, 8'h0F, 1'b1);
      rd_chk(8'h50, 1'b1, "R3");
      rd_chk(8'h40, 1'b1, "R1");
      rd_chk(8'h4F, 1'b1, "R1");
      apply_cfg(2'b10, 3'd0);
      frame_chk(2'b10, 4);             // pin 15 as fourth common (R5)
      apply_cfg(2'b00, 3'd0);
      rd_chk(8'h47, 1'b1, "R3");       // upper bits masked at two commons
      frame_chk(2'b00, 4);             // pin 15 plain segment, com 2 idle (R5)

      // mid-frame change waits for the boundary (R9)
      apply_cfg(2'b11, 3'd0);
      sync_frame();
      repeat (2 + 4 + 4) @(negedge clk);
      phase_chk(1, 0, 2'b11, "R9");
      cfg_duty = 2'b00;
      cfg_div = 3'd1;
      for (int s = 3; s < 8; s++) begin
         repeat (4) @(negedge clk);
         phase_chk(s / 2, s % 2, 2'b11, "R9");
      end
      frame_chk(2'b00, 8);
      period_chk(8);

      // randomized configurations and pixels, written while running (R2)
      for (int it = 0; it < 10; it++) begin
         d = 2'($urandom % 4);
         v = 3'($urandom % 4);
         for (int w = 0; w < 6; w++)
            wr(8'h40 + 8'($urandom % 16), 8'($urandom), 1'($urandom % 4 != 0));
         rd_chk(8'h40 + 8'($urandom % 16), 1'b1, "R3");
         apply_cfg(d, v);
         frame_chk(d, per(v));
         period_chk(per(v));
      end

      // saturated divider code (R6)
      apply_cfg(2'b00, 3'd7);
      period_chk(256);
      frame_chk(2'b00, 256);

      // halt mid-frame goes dark next cycle (R8)
      @(negedge clk);
      halt = 1'b1;
      @(negedge clk);
      all_dark_chk("R8");
      halt = 1'b0;

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end
endmodule